// File: doc/BRIEF.md
# Counter Machine Instruction Sequencer

This block is a small register machine that steps through a program of counter operations. The program sits in its own instruction table, apart from the data, and acts on a bank of unsigned counter registers. Four operations exist: add one to a register, take one away from a register, branch to a target when a register reads zero, and stop. Each instruction is fetched, decoded and carried out in a single clock cycle, and the instruction register moves on at that same edge.

A host writes the program through a load port and sets initial counter values through a preload port while the machine sits idle. It then pulses start. The machine runs until it meets a stop instruction or runs off the end of the loaded program, and then raises its halted flag. Counter contents are read back through a combinational debug port, and the instruction register is visible at all times. Counters never go below zero and never wrap: taking one from zero leaves zero, and adding one to the all-ones value leaves it there and raises a sticky overflow flag.

Top module: `cmSequencer`

## Requirements
- R1: After reset, halted is 1, dbgIr is 0, overflow is 0 and every counter reads 0 through the debug port.
- R2: An instruction word holds the opcode in bits [8:7], the register index in bits [6:4] and the jump target in bits [3:0] (default sizes). Opcode 00 adds one to the indexed register and moves dbgIr up by one, in one cycle.
- R3: Opcode 00 on a register that holds all ones leaves it at all ones and sets overflow. Overflow stays set until the next start or reset.
- R4: Opcode 01 takes one from the indexed register and moves dbgIr up by one. When the register holds zero it stays zero.
- R5: Opcode 10 loads the jump target into dbgIr when the indexed register holds zero, and otherwise moves dbgIr up by one. It never changes a counter.
- R6: Opcode 11 sets halted and leaves dbgIr on the stop instruction. While halted and without start, dbgIr and all counters hold their values.
- R7: The high-water mark of the table is one past the highest address written since reset. Fetching at or beyond it acts as opcode 11.
- R8: A start pulse sets dbgIr to 0, clears halted and clears overflow at the next edge. The instruction at address 0 executes at the edge after that.
- R9: A preload write sets the indexed counter to the given value at the next edge. dbgData shows the counter chosen by dbgIdx without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| progWe | input | 1 | Write strobe for the instruction table |
| progAddr | input | 4 | Table address to write |
| progData | input | 9 | Instruction word to write |
| start | input | 1 | Restarts execution at address 0 |
| preWe | input | 1 | Write strobe for a counter preload |
| preIdx | input | 3 | Counter to preload |
| preData | input | 8 | Preload value |
| dbgIdx | input | 3 | Counter chosen for debug read |
| dbgData | output | 8 | Value of the chosen counter |
| dbgIr | output | 4 | Current instruction register |
| halted | output | 1 | Machine is stopped |
| overflow | output | 1 | Sticky flag: an add met all ones |

## Verification
The bench goes after counters at the two ends of their range. An add at 255 that wrapped would give 0 and leave overflow low, and a subtract at 0 that wrapped would give 255. Branches are tested both taken and not taken, with targets inside and beyond the loaded program; a design that ignored the high-water mark would run stale or unloaded words instead of stopping with dbgIr on the first unloaded address. It also checks that start clears overflow before the first instruction runs, and that a halted machine keeps dbgIr and the counters fixed across idle cycles. A design that stepped past the stop word, or dropped the stale flag a cycle late, fails these checks.

// File: rtl/cm_pkg.sv
package cm_pkg;

  typedef enum logic [1:0] {
    OP_INC  = 2'b00,
    OP_DEC  = 2'b01,
    OP_JZ   = 2'b10,
    OP_HALT = 2'b11
  } cmOp_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic incStb;
    logic decStb;
    logic clrOvf;
  } cmStrobe_t;

endpackage

// File: rtl/cmProgTable.sv
module cmProgTable #(
  parameter int PROG_DEPTH = 16,
  parameter int WORD_W     = 9,
  localparam int PC_W      = $clog2(PROG_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progWe,
  input  logic [PC_W-1:0]   progAddr,
  input  logic [WORD_W-1:0] progData,
  input  logic [PC_W-1:0]   rdAddr,
  output logic [WORD_W-1:0] rdWord,
  output logic              rdValid
);

  logic [WORD_W-1:0] mem [PROG_DEPTH];
  logic [PC_W:0]     progEnd;
  logic [PC_W:0]     wrNext;

  assign wrNext = (PC_W+1)'(progAddr) + (PC_W+1)'(1);

  always_ff @(posedge clk) begin
    if (progWe) mem[progAddr] <= progData;
  end

  // High-water mark of loaded addresses (R7)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      progEnd <= '0;
    end else if (progWe && (wrNext > progEnd)) begin
      progEnd <= wrNext;
    end
  end

  assign rdWord  = mem[rdAddr];
  assign rdValid = ((PC_W+1)'(rdAddr) < progEnd);

  a_r7_mark_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    progWe |=> (progEnd >= $past(wrNext)));

  a_r7_mark_no_shrink: assert property (@(posedge clk) disable iff (!rstN)
    !progWe |=> $stable(progEnd));

endmodule

// File: rtl/cmControl.sv
module cmControl
  import cm_pkg::*;
#(
  parameter int REG_COUNT  = 8,
  parameter int PROG_DEPTH = 16,
  localparam int PC_W      = $clog2(PROG_DEPTH),
  localparam int IDX_W     = $clog2(REG_COUNT),
  localparam int WORD_W    = 2 + IDX_W + PC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] fetchWord,
  input  logic              fetchValid,
  input  logic              regZero,
  output logic [PC_W-1:0]   ir,
  output logic              halted,
  output logic [IDX_W-1:0]  regIdx,
  output cmStrobe_t         strb
);

  cmOp_e           op;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] irStep;
  logic [PC_W-1:0] nextIr;
  logic            nextHalted;

  assign op     = cmOp_e'(fetchWord[WORD_W-1 -: 2]);
  assign regIdx = fetchWord[PC_W +: IDX_W];
  assign target = fetchWord[PC_W-1:0];
  assign irStep = ir + PC_W'(1);

  always_comb begin
    strb       = '0;
    nextIr     = ir;
    nextHalted = halted;
    if (start) begin
      nextIr      = '0;
      nextHalted  = 1'b0;
      strb.clrOvf = 1'b1;
    end else if (!halted) begin
      if (!fetchValid) begin
        nextHalted = 1'b1;
      end else begin
        unique case (op)
          OP_INC: begin
            strb.incStb = 1'b1;
            nextIr      = irStep;
          end
          OP_DEC: begin
            strb.decStb = 1'b1;
            nextIr      = irStep;
          end
          OP_JZ: begin
            nextIr = regZero ? target : irStep;
          end
          OP_HALT: begin
            nextHalted = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ir     <= '0;
      halted <= 1'b1;
    end else begin
      ir     <= nextIr;
      halted <= nextHalted;
    end
  end

  a_r6_halt_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !start) |=> (halted && $stable(ir)));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (ir == '0 && !halted));

  a_r5_jz_taken: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !start && fetchValid && op == OP_JZ && regZero)
      |=> (ir == $past(target)));

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !start && fetchValid && (op == OP_INC || op == OP_DEC))
      |=> (ir == $past(irStep) && !halted));

  a_r7_end_halts: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !start && !fetchValid) |=> (halted && $stable(ir)));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.incStb, strb.decStb, strb.clrOvf}));

endmodule

// File: rtl/cmDatapath.sv
module cmDatapath
  import cm_pkg::*;
#(
  parameter int REG_COUNT = 8,
  parameter int REG_WIDTH = 8,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cmStrobe_t            strb,
  input  logic [IDX_W-1:0]     regIdx,
  input  logic                 preWe,
  input  logic [IDX_W-1:0]     preIdx,
  input  logic [REG_WIDTH-1:0] preData,
  input  logic [IDX_W-1:0]     dbgIdx,
  output logic [REG_WIDTH-1:0] dbgData,
  output logic                 regZero,
  output logic                 overflow
);

  localparam logic [REG_WIDTH-1:0] ALL_ONES = '1;

  logic [REG_WIDTH-1:0] regVec [REG_COUNT];
  logic [REG_WIDTH-1:0] selVal;
  logic                 selFull;
  logic                 preHitSel;

  assign selVal    = regVec[regIdx];
  assign selFull   = (selVal == ALL_ONES);
  assign regZero   = (selVal == '0);
  assign preHitSel = preWe && (preIdx == regIdx);
  assign dbgData   = regVec[dbgIdx];

  for (genvar g = 0; g < REG_COUNT; g++) begin : gCounter
    logic [REG_WIDTH-1:0] cnt;
    logic                 isSel;

    assign isSel = (regIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (preWe && preIdx == IDX_W'(g)) begin
        cnt <= preData;
      end else if (isSel && strb.incStb && cnt != ALL_ONES) begin
        cnt <= cnt + REG_WIDTH'(1);
      end else if (isSel && strb.decStb && cnt != '0) begin
        cnt <= cnt - REG_WIDTH'(1);
      end
    end

    assign regVec[g] = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overflow <= 1'b0;
    end else if (strb.clrOvf) begin
      overflow <= 1'b0;
    end else if (strb.incStb && selFull) begin
      overflow <= 1'b1;
    end
  end

  a_r3_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incStb && selFull && !preHitSel)
      |=> (regVec[$past(regIdx)] == ALL_ONES && overflow));

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strb.clrOvf) |=> overflow);

  a_r4_dec_floor: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decStb && regZero && !preHitSel) |=> (regVec[$past(regIdx)] == '0));

  a_r2_inc_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incStb && !selFull && !preHitSel)
      |=> (regVec[$past(regIdx)] == $past(selVal) + REG_WIDTH'(1)));

  a_r9_preload: assert property (@(posedge clk) disable iff (!rstN)
    preWe |=> (regVec[$past(preIdx)] == $past(preData)));

endmodule

// File: rtl/cmSequencer.sv
module cmSequencer
  import cm_pkg::*;
#(
  parameter int REG_COUNT  = 8,
  parameter int REG_WIDTH  = 8,
  parameter int PROG_DEPTH = 16,
  localparam int PC_W      = $clog2(PROG_DEPTH),
  localparam int IDX_W     = $clog2(REG_COUNT),
  localparam int WORD_W    = 2 + IDX_W + PC_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 progWe,
  input  logic [PC_W-1:0]      progAddr,
  input  logic [WORD_W-1:0]    progData,
  input  logic                 start,
  input  logic                 preWe,
  input  logic [IDX_W-1:0]     preIdx,
  input  logic [REG_WIDTH-1:0] preData,
  input  logic [IDX_W-1:0]     dbgIdx,
  output logic [REG_WIDTH-1:0] dbgData,
  output logic [PC_W-1:0]      dbgIr,
  output logic                 halted,
  output logic                 overflow
);

  logic [WORD_W-1:0] fetchWord;
  logic              fetchValid;
  logic              regZero;
  logic [IDX_W-1:0]  regIdx;
  logic [PC_W-1:0]   ir;
  cmStrobe_t         strb;

  cmProgTable #(
    .PROG_DEPTH (PROG_DEPTH),
    .WORD_W     (WORD_W)
  ) uTable (
    .clk      (clk),
    .rstN     (rstN),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .rdAddr   (ir),
    .rdWord   (fetchWord),
    .rdValid  (fetchValid)
  );

  cmControl #(
    .REG_COUNT  (REG_COUNT),
    .PROG_DEPTH (PROG_DEPTH)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .fetchWord  (fetchWord),
    .fetchValid (fetchValid),
    .regZero    (regZero),
    .ir         (ir),
    .halted     (halted),
    .regIdx     (regIdx),
    .strb       (strb)
  );

  cmDatapath #(
    .REG_COUNT (REG_COUNT),
    .REG_WIDTH (REG_WIDTH)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regIdx   (regIdx),
    .preWe    (preWe),
    .preIdx   (preIdx),
    .preData  (preData),
    .dbgIdx   (dbgIdx),
    .dbgData  (dbgData),
    .regZero  (regZero),
    .overflow (overflow)
  );

  assign dbgIr = ir;

endmodule

// File: tb/cmSequencer_test.sv
`timescale 1ns/1ps
module cmSequencer_test;

  localparam int NREG  = 8;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       progWe = 1'b0;
  logic [3:0] progAddr = '0;
  logic [8:0] progData = '0;
  logic       start = 1'b0;
  logic       preWe = 1'b0;
  logic [2:0] preIdx = '0;
  logic [7:0] preData = '0;
  logic [2:0] dbgIdx = '0;
  logic [7:0] dbgData;
  logic [3:0] dbgIr;
  logic       halted;
  logic       overflow;

  int cmpCount = 0;
  int misCount = 0;
  bit done = 1'b0;

  // reference model state
  logic [8:0] mProg [DEPTH];
  int         mRegs [NREG];
  int         mIr;
  int         mEnd;
  bit         mHalted;
  bit         mOvf;

  always #5 clk = ~clk;

  cmSequencer uut (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progAddr(progAddr),
    .progData(progData), .start(start), .preWe(preWe), .preIdx(preIdx),
    .preData(preData), .dbgIdx(dbgIdx), .dbgData(dbgData), .dbgIr(dbgIr),
    .halted(halted), .overflow(overflow)
  );

  function automatic logic [8:0] mkWord(int op, int idx, int tgt);
    return {2'(op), 3'(idx), 4'(tgt)};
  endfunction

  function automatic void mStep();
    logic [8:0] w;
    int op, idx;
    if (mHalted) return;
    if (mIr >= mEnd) begin mHalted = 1; return; end
    w = mProg[mIr];
    op = int'(w[8:7]);
    idx = int'(w[6:4]);
    case (op)
      0: begin
        if (mRegs[idx] == 255) mOvf = 1; else mRegs[idx]++;
        mIr = (mIr + 1) % DEPTH;
      end
      1: begin
        if (mRegs[idx] > 0) mRegs[idx]--;
        mIr = (mIr + 1) % DEPTH;
      end
      2: mIr = (mRegs[idx] == 0) ? int'(w[3:0]) : (mIr + 1) % DEPTH;
      default: mHalted = 1;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    cmpCount++;
    if (act != exp) begin
      misCount++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; progWe = 0; start = 0; preWe = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    foreach (mRegs[i]) mRegs[i] = 0;
    mIr = 0; mEnd = 0; mHalted = 1; mOvf = 0;
  endtask

  task automatic loadWord(int addr, logic [8:0] w);
    progWe = 1'b1; progAddr = 4'(addr); progData = w;
    @(negedge clk);
    progWe = 1'b0;
    mProg[addr] = w;
    if (addr + 1 > mEnd) mEnd = addr + 1;
  endtask

  task automatic preload(int idx, int val);
    preWe = 1'b1; preIdx = 3'(idx); preData = 8'(val);
    @(negedge clk);
    preWe = 1'b0;
    mRegs[idx] = val;
  endtask

  task automatic runFor(int steps);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mIr = 0; mHalted = 0; mOvf = 0;
    for (int s = 0; s < steps; s++) begin
      @(negedge clk);
      mStep();
    end
  endtask

  task automatic idle(int cycles);
    for (int s = 0; s < cycles; s++) begin
      @(negedge clk);
      mStep();
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "halted", int'(halted), int'(mHalted));
    chk(tag, "dbgIr", int'(dbgIr), mIr);
    chk(tag, "overflow", int'(overflow), int'(mOvf));
    for (int i = 0; i < NREG; i++) begin
      dbgIdx = 3'(i);
      #0.4;
      chk(tag, $sformatf("reg%0d", i), int'(dbgData), mRegs[i]);
    end
  endtask

  function automatic int pickVal();
    int r = $urandom % 5;
    case (r)
      0: return 0;
      1: return 1;
      2: return 254;
      3: return 255;
      default: return $urandom % 256;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h00C0FFEE));
    doReset();
    compareAll("R1 reset");

    // R9: preload and debug read
    preload(3, 77);
    preload(5, 200);
    compareAll("R9 preload");

    // R2/R3: increment into saturation, overflow sticky, halt freezes
    preload(1, 254);
    loadWord(0, mkWord(0, 1, 0));
    loadWord(1, mkWord(0, 1, 0));
    loadWord(2, mkWord(0, 1, 0));
    loadWord(3, mkWord(3, 0, 0));
    runFor(5);
    compareAll("R3 saturate");
    idle(6);
    compareAll("R6 halt hold");
    runFor(0);
    compareAll("R8 start clears overflow");
    idle(5);

    // R4: decrement down to zero and beyond
    doReset();
    preload(2, 2);
    for (int a = 0; a < 4; a++) loadWord(a, mkWord(1, 2, 0));
    loadWord(4, mkWord(3, 0, 0));
    runFor(2);
    compareAll("R4 dec mid");
    idle(4);
    compareAll("R4 dec floor");

    // R5: jump taken and not taken; R7 target beyond end
    doReset();
    preload(4, 1);
    loadWord(0, mkWord(2, 4, 5));   // reg4=1 -> not taken
    loadWord(1, mkWord(1, 4, 0));   // reg4 -> 0
    loadWord(2, mkWord(2, 4, 9));   // taken to 9 (beyond end)
    loadWord(3, mkWord(0, 0, 0));
    runFor(3);
    compareAll("R5 jz taken");
    idle(2);
    compareAll("R7 beyond end");

    // R7: program without halt runs off the end
    doReset();
    loadWord(0, mkWord(0, 0, 0));
    loadWord(1, mkWord(0, 0, 0));
    runFor(4);
    compareAll("R7 off end");

    // R2: counting loop via jz on a zero register
    doReset();
    preload(6, 3);
    loadWord(0, mkWord(2, 6, 4));
    loadWord(1, mkWord(1, 6, 0));
    loadWord(2, mkWord(0, 7, 0));
    loadWord(3, mkWord(2, 0, 0));   // reg0 is 0 -> back to 0
    loadWord(4, mkWord(3, 0, 0));
    runFor(20);
    compareAll("R2 loop");

    // random programs
    for (int t = 0; t < 40; t++) begin
      int len, steps;
      doReset();
      len = 2 + ($urandom % 15);
      for (int a = 0; a < len; a++) begin
        int r = $urandom % 8;
        int op = (r < 3) ? 0 : (r < 5) ? 1 : (r < 7) ? 2 : 3;
        loadWord(a, mkWord(op, $urandom % 4, $urandom % 16));
      end
      for (int i = 0; i < 4; i++) preload(i, pickVal());
      steps = 1 + ($urandom % 60);
      runFor(steps);
      compareAll($sformatf("R2 R4 R5 random %0d", t));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCount, misCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misCount++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCount, misCount);
      $finish;
    end
  end

endmodule